// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the processor reset for a supply supervisor. It takes two reset sources: an under-voltage flag from an external threshold comparator (high while the supply is too low) and a manual reset request that is active low. Both pass through multi-flop synchronizers. The reset outputs come up as soon as either synchronized source is active. They stay up for a fixed number of clock cycles after the last source lets go.

The hold time is a cycle count. By default it is computed from the clock frequency and a hold time in microseconds, 200 ms nominal. Any new source activity during the hold reloads the timer to its full value. This makes the block a retriggerable reset stretcher rather than a one-shot. It also means the manual input needs no debouncer of its own, because a bounce shorter than the hold time only restarts the timeout.

Reset is driven in both polarities, and a status output shows when the hold timer is counting down. After its own synchronous reset the block begins with the processor reset active and runs one full hold period before it releases.

Top module: `supv_reset_gen`

## Requirements
- R1: When `vlow_i` is driven high (under-voltage) and reset was released, `rst_o` is still 0 after the second rising edge that samples it and is 1 after the third.
- R2: When `mr_n_i` is driven low (manual request), `rst_o` is still 0 after the second rising edge that samples it and is 1 after the third.
- R3: Let edge 1 be the first rising edge at which both sources are sampled inactive (`vlow_i`=0, `mr_n_i`=1). After edge HOLD_CYCLES+1, `rst_o` is still 1. After edge HOLD_CYCLES+2, `rst_o` is 0.
- R4: A source that becomes active for even one sampled cycle while the hold is running restarts the hold. R3 then applies counted from that new release.
- R5: Manual-input bounces made of low pulses separated by high gaps shorter than HOLD_CYCLES keep reset asserted throughout. Reset releases HOLD_CYCLES+2 edges after the final release.
- R6: `rst_n_o` is always the exact complement of `rst_o`.
- R7: While `rst_n` is low and a clock runs, `rst_o` is 1 and `hold_busy_o` is 0. In this case edge 1 of R3 is the first rising edge with `rst_n` high, and R3 applies with idle inputs.
- R8: `hold_busy_o` is 1 exactly when reset is held with both synchronized sources inactive: from edge 2 through edge HOLD_CYCLES+1 of a release. It is 0 while a source is active and while reset is released.
- R9: With both sources idle and reset released, `rst_o` stays 0. No other condition asserts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous block reset, active low |
| vlow_i | input | 1 | Under-voltage flag, 1 = supply low (asynchronous) |
| mr_n_i | input | 1 | Manual reset request, 0 = request (asynchronous) |
| rst_o | output | 1 | Processor reset, active high |
| rst_n_o | output | 1 | Processor reset, active low |
| hold_busy_o | output | 1 | 1 while the hold timer counts down |

## Verification
A hold counter that fails to reload shows as a release at the ports too early. A retrigger within the hold, or the edge of a bounce, exposes this within HOLD_CYCLES+2 cycles of the last release. An off-by-one in the counter moves the falling edge of `rst_o` by one cycle, so the bench samples exactly on both sides of that edge. A synchronizer with the wrong depth or the wrong reset value shifts the assertion edge, or the release edge after block reset, by a cycle. The status output exposes a counter that runs while a source is still active, because `hold_busy_o` rises early.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Hold period in clock cycles from frequency and time; never below one.
  function automatic int unsigned hold_cycles(longint unsigned clk_hz,
                                              longint unsigned hold_us);
    longint unsigned c;
    c = (clk_hz * hold_us) / 64'd1000000;
    if (c < 64'd1) c = 64'd1;
    return c[31:0];
  endfunction

  // Bits needed to hold values 0..n.
  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned W       = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n) sh <= {STAGES{RST_VAL[b]}};
      else        sh <= {sh[STAGES-2:0], d[b]};
    end
    assign q[b] = sh[STAGES-1];
  end

endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 8,
  parameter int unsigned CW          = supv_pkg::cnt_width(HOLD_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_act,
  output logic rst_act,
  output logic busy
);

  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt;
  logic          cnt_nz;
  logic          cnt_last;

  assign cnt_nz   = (cnt != '0);
  assign cnt_last = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= LOAD;
      rst_act <= 1'b1;
    end else if (src_act) begin
      cnt     <= LOAD;
      rst_act <= 1'b1;
    end else if (cnt_nz) begin
      cnt <= cnt - CW'(1);
      if (cnt_last) rst_act <= 1'b0;
    end
  end

  assign busy = cnt_nz & ~src_act;

  // R1 / R2: an active source always leaves reset asserted next cycle
  a_r1_source_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    src_act |=> rst_act);

  // R8: counting implies reset is held
  a_r8_busy_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rst_act);

  // R9: released and idle stays released
  a_r9_idle_stays_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_act && !src_act) |=> !rst_act);

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
  parameter int unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned HOLD_US     = 200_000,
  parameter int unsigned HOLD_CYCLES = supv_pkg::hold_cycles(64'(CLK_HZ), 64'(HOLD_US)),
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vlow_i,
  input  logic mr_n_i,
  output logic rst_o,
  output logic rst_n_o,
  output logic hold_busy_o
);

  localparam int unsigned CW = supv_pkg::cnt_width(HOLD_CYCLES);

  // bit 1 = under-voltage (active high), bit 0 = manual (active low);
  // both reset to their active level so reset holds through block reset
  logic [1:0] src_raw;
  logic [1:0] src_syn;
  logic       vlow_s;
  logic       mr_n_s;
  logic       src_act;
  logic       rst_act;
  logic       busy;

  assign src_raw = {vlow_i, mr_n_i};

  supv_sync #(
    .W      (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b10)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (src_raw),
    .q    (src_syn)
  );

  assign vlow_s  = src_syn[1];
  assign mr_n_s  = src_syn[0];
  assign src_act = vlow_s | ~mr_n_s;

  supv_hold_timer #(
    .HOLD_CYCLES(HOLD_CYCLES),
    .CW         (CW)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_act(src_act),
    .rst_act(rst_act),
    .busy   (busy)
  );

  assign rst_o       = rst_act;
  assign rst_n_o     = ~rst_act;
  assign hold_busy_o = busy;

  // Checker: cycles with the synchronized sources quiet, saturating
  logic [CW:0] quiet_q;
  always_ff @(posedge clk) begin
    if (!rst_n || src_act)                      quiet_q <= '0;
    else if (quiet_q <= (CW+1)'(HOLD_CYCLES))   quiet_q <= quiet_q + (CW+1)'(1);
  end

  // R3 / R4: release happens only after exactly a full quiet hold
  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_act) |-> (quiet_q == (CW+1)'(HOLD_CYCLES)));

  // R3: a full quiet hold never leaves reset asserted
  a_r3_no_overstay: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q > (CW+1)'(HOLD_CYCLES)) |-> !rst_act);

endmodule

// File: tb/supv_reset_gen_test.sv
`timescale 1ns/100ps
module supv_reset_gen_test;

  localparam int unsigned H = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic vlow_i;
  logic mr_n_i;
  logic rst_o;
  logic rst_n_o;
  logic hold_busy_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  supv_reset_gen #(.HOLD_CYCLES(H)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .vlow_i     (vlow_i),
    .mr_n_i     (mr_n_i),
    .rst_o      (rst_o),
    .rst_n_o    (rst_n_o),
    .hold_busy_o(hold_busy_o)
  );

  // {vlow, mr_n, pulse length}
  localparam int NV = 6;
  localparam logic [9:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'd5},
    {1'b0, 1'b0, 8'd4},
    {1'b1, 1'b0, 8'd3},
    {1'b0, 1'b0, 8'd1},
    {1'b1, 1'b1, 8'd1},
    {1'b1, 1'b1, 8'd20}
  };

  // advance n rising edges, then sit 1 ns after the last one
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic expect_rst(input string req, input logic e_rst);
    chk(req, "rst_o", rst_o, e_rst);
    chk("R6", "rst_n_o", rst_n_o, ~e_rst);
  endtask

  task automatic expect_all(input string req, input logic e_rst, input logic e_busy);
    expect_rst(req, e_rst);
    chk((req == "R7") ? "R7" : "R8", "hold_busy_o", hold_busy_o, e_busy);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n  = 1'b0;
    vlow_i = 1'b0;
    mr_n_i = 1'b1;
    tick(3);
    // R7: reset state
    expect_all("R7", 1'b1, 1'b0);
    rst_n = 1'b1;
    tick(H + 1);
    expect_all("R7", 1'b1, 1'b1);
    tick(1);
    expect_all("R7", 1'b0, 1'b0);

    // R9: idle keeps reset released
    for (int i = 0; i < 5; i++) begin
      tick(10);
      expect_all("R9", 1'b0, 1'b0);
    end

    // Vector walk: R1/R2 latency, R3 hold length, R8 status
    for (int v = 0; v < NV; v++) begin
      int len;
      string tag;
      len    = int'(VEC[v][7:0]);
      tag    = VEC[v][9] ? "R1" : "R2";
      vlow_i = VEC[v][9];
      mr_n_i = VEC[v][8];
      if (len >= 3) begin
        tick(2);
        expect_all(tag, 1'b0, 1'b0);
        tick(1);
        expect_all(tag, 1'b1, 1'b0);
        tick(len - 3);
      end else begin
        tick(len);
      end
      vlow_i = 1'b0;
      mr_n_i = 1'b1;
      tick(H + 1);
      expect_all("R3", 1'b1, 1'b1);
      tick(1);
      expect_all("R3", 1'b0, 1'b0);
      tick(3);
    end

    // R4: retrigger during the hold
    mr_n_i = 1'b0;
    tick(3);
    expect_all("R2", 1'b1, 1'b0);
    mr_n_i = 1'b1;
    tick(5);
    expect_all("R4", 1'b1, 1'b1);
    vlow_i = 1'b1;
    tick(1);
    vlow_i = 1'b0;
    tick(4);
    // original hold would have ended here
    expect_all("R4", 1'b1, 1'b1);
    tick(H + 1 - 4);
    expect_all("R4", 1'b1, 1'b1);
    tick(1);
    expect_all("R4", 1'b0, 1'b0);
    tick(3);

    // R5: bouncing manual input
    mr_n_i = 1'b0; tick(1);
    mr_n_i = 1'b1; tick(2);
    expect_rst("R5", 1'b1);
    mr_n_i = 1'b0; tick(1);
    expect_rst("R5", 1'b1);
    mr_n_i = 1'b1; tick(3);
    expect_rst("R5", 1'b1);
    mr_n_i = 1'b0; tick(2);
    expect_rst("R5", 1'b1);
    mr_n_i = 1'b1;
    tick(H + 1);
    expect_all("R5", 1'b1, 1'b1);
    tick(1);
    expect_all("R5", 1'b0, 1'b0);

    // R9: long idle after all activity
    tick(40);
    expect_all("R9", 1'b0, 1'b0);

    finish_run();
  end

endmodule